// File: doc/BRIEF.md
# Display Frame Parameter Decoder

This block sits between the display configuration registers and the scanout engine. On every frame strobe it takes one sample of the geometry word, the pixel mode, the enable, interlace and blank controls, the border colour and the frame base address. From these it computes the parameters that the scanout engine reads for the whole of the next frame: base address, row pitch in bytes, horizontal and vertical resolution, and pixel format. It also reports one of three display states.

- `ST_OFF`: output is disabled.
- `ST_SHOW`: the frame buffer is shown.
- `ST_BLANK`: a solid frame is filled with the sampled border colour.

The block keeps the resolution and format of recent enabled frames in a two-slot ping-pong store. Each enabled frame writes the current slot. The new values are compared with the other slot, and the pointer then toggles. When they differ, `fmt_changed` pulses for one cycle so that downstream logic can reconfigure. A disabled frame resets the pointer to slot 0 and zeroes that slot's resolutions.

The state machine moves only on `frame_tick`. From any state it takes one of three transitions:
- **go_off**: output not enabled, so the next state is `ST_OFF`.
- **go_blank**: output enabled and blanking requested, so the next state is `ST_BLANK`.
- **go_show**: output enabled without blanking, so the next state is `ST_SHOW`.

Without a strobe every state holds.

Top module: `frame_param_decoder`

## Requirements
- R1: After reset all outputs are zero, and the state is `ST_OFF` (`fb_enable`=0, `fb_blank`=0).
- R2: On an enabled frame, `fb_row_bytes` = (geom_reg[9:0] + geom_reg[29:20]) * 4. This is the words-per-line field plus one, added to the stride field minus one, all times four.
- R3: On an enabled frame, `fb_vres` = geom_reg[19:10] + 1, doubled when `interlace` is 1.
- R4: On an enabled frame, `fb_fmt` = `pix_mode`, with W = geom_reg[9:0] + 1. Then `fb_hres` is:
  - for modes 0 (ARGB1555) and 1 (RGB565): 2*W;
  - for mode 2 (packed 24-bit): floor(4*W/3);
  - for mode 3 (32-bit ARGB): W.
- R5: The output is enabled (`fb_enable`=1 after the strobe) only when both `disp_en` and `vid_out` are 1.
- R6: On an enabled frame with `blank_req`=1, `fb_blank` becomes 1. `fb_fill` always takes the sampled `border_rgb` on an enabled frame, and `fb_base` takes `disp_base`.
- R7: Outputs change only in the cycle after a `frame_tick`. Input changes without a strobe have no effect.
- R8: `fmt_changed` is a single-cycle pulse after an enabled strobe. It fires when the new hres, vres or format differs from the value held in the other ping-pong slot.
- R9: A disabled strobe resets the slot pointer to 0 and zeroes slot 0's resolutions. It raises no pulse and leaves the parameter outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame boundary strobe, one cycle |
| disp_base | input | ADDR_W | Frame buffer start address |
| geom_reg | input | 3*FIELD_W | Geometry word: words/line, lines/field, stride fields |
| pix_mode | input | 2 | Pixel format select |
| disp_en | input | 1 | Display enable control |
| vid_out | input | 1 | Video output control |
| interlace | input | 1 | Interlaced scan select |
| blank_req | input | 1 | Blank-to-border request |
| border_rgb | input | COLOR_W | Border colour value |
| fb_base | output | ADDR_W | Registered start address |
| fb_row_bytes | output | FIELD_W+3 | Registered row pitch in bytes |
| fb_hres | output | FIELD_W+2 | Registered horizontal resolution |
| fb_vres | output | FIELD_W+2 | Registered vertical resolution |
| fb_fmt | output | 2 | Registered pixel format |
| fb_enable | output | 1 | Output enabled (state is not `ST_OFF`) |
| fb_blank | output | 1 | Blank frame (state is `ST_BLANK`) |
| fb_fill | output | COLOR_W | Registered border colour |
| fmt_changed | output | 1 | Reconfigure pulse |

## Verification
Two functions can act in the same strobe cycle: a state transition (`go_show` to `go_blank`, or into `go_off`), and the ping-pong compare with its pulse or the pointer reset. The bench provokes both together:
- it toggles blank and enable in the same frame as changes of mode or geometry;
- it runs the sequence A, B, A, off, B, where a stale pointer or an uncleared slot would produce a spurious pulse.

A bench model tracks both slots and the pointer arithmetically. It judges every output, including the pulse and its drop one cycle later, after each strobe.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [1:0] {
        PIX_1555 = 2'd0,
        PIX_565  = 2'd1,
        PIX_888  = 2'd2,
        PIX_8888 = 2'd3
    } pix_fmt_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SHOW  = 2'd1,
        ST_BLANK = 2'd2
    } disp_state_t;

endpackage

// File: rtl/fpd_geom_unpack.sv
module fpd_geom_unpack #(
    parameter int FIELD_W = 10
) (
    input  logic [3*FIELD_W-1:0] geom,
    output logic [FIELD_W:0]     words,
    output logic [FIELD_W:0]     lines,
    output logic [FIELD_W+2:0]   row_bytes
);
    localparam int LINES_LSB  = FIELD_W;
    localparam int STRIDE_LSB = 2 * FIELD_W;

    logic [FIELD_W-1:0] words_raw;
    logic [FIELD_W-1:0] lines_raw;
    logic [FIELD_W-1:0] stride_raw;
    logic [FIELD_W:0]   pitch_words;

    assign words_raw  = geom[FIELD_W-1:0];
    assign lines_raw  = geom[LINES_LSB +: FIELD_W];
    assign stride_raw = geom[STRIDE_LSB +: FIELD_W];

    // (raw+1) + (stride-1) collapses to raw + stride
    assign words       = {1'b0, words_raw} + 1'b1;
    assign lines       = {1'b0, lines_raw} + 1'b1;
    assign pitch_words = {1'b0, words_raw} + {1'b0, stride_raw};
    assign row_bytes   = {pitch_words, 2'b00};

endmodule

// File: rtl/fpd_hres_calc.sv
module fpd_hres_calc
    import fpd_pkg::*;
#(
    parameter int FIELD_W = 10
) (
    input  logic [FIELD_W:0]   words,
    input  pix_fmt_t           fmt,
    output logic [FIELD_W+1:0] hres
);
    localparam int HRES_W = FIELD_W + 2;
    localparam int DIV_W  = FIELD_W + 3;
    localparam int SHIFT  = DIV_W + 1;
    localparam int PROD_W = DIV_W + SHIFT;
    localparam logic [PROD_W-1:0] RECIP = PROD_W'(((64'd1 << SHIFT) / 3) + 1);

    logic [DIV_W-1:0]  bytes4;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [HRES_W-1:0] hres_16;
    logic [HRES_W-1:0] hres_24;
    logic [HRES_W-1:0] hres_32;

    assign bytes4  = {words, 2'b00};
    assign prod    = PROD_W'(bytes4) * RECIP;
    assign quot    = prod >> SHIFT;
    assign hres_24 = quot[HRES_W-1:0];
    assign hres_16 = {words, 1'b0};
    assign hres_32 = {1'b0, words};

    always_comb begin
        unique case (fmt)
            PIX_1555, PIX_565: hres = hres_16;
            PIX_888:           hres = hres_24;
            PIX_8888:          hres = hres_32;
            default:           hres = hres_32;
        endcase
    end

endmodule

// File: rtl/fpd_slot_pair.sv
module fpd_slot_pair
    import fpd_pkg::*;
#(
    parameter int HRES_W = 12,
    parameter int VRES_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr,
    input  logic [HRES_W-1:0] hres_in,
    input  logic [VRES_W-1:0] vres_in,
    input  pix_fmt_t          fmt_in,
    output logic              differs
);
    localparam int SLOTS = 2;

    logic              ptr;
    logic [HRES_W-1:0] s_hres [SLOTS];
    logic [VRES_W-1:0] s_vres [SLOTS];
    pix_fmt_t          s_fmt  [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic SEL = (g == 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_hres[g] <= '0;
                s_vres[g] <= '0;
                s_fmt[g]  <= PIX_1555;
            end else if (wr_en && ptr == SEL) begin
                s_hres[g] <= hres_in;
                s_vres[g] <= vres_in;
                s_fmt[g]  <= fmt_in;
            end else if (clr && !SEL) begin
                s_hres[g] <= '0;
                s_vres[g] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= 1'b0;
        else if (clr)   ptr <= 1'b0;
        else if (wr_en) ptr <= ~ptr;
    end

    always_comb begin
        differs = (hres_in != s_hres[~ptr]) ||
                  (vres_in != s_vres[~ptr]) ||
                  (fmt_in  != s_fmt[~ptr]);
    end

endmodule

// File: rtl/frame_param_decoder.sv
module frame_param_decoder
    import fpd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int FIELD_W = 10,
    parameter int COLOR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_tick,
    input  logic [ADDR_W-1:0]    disp_base,
    input  logic [3*FIELD_W-1:0] geom_reg,
    input  logic [1:0]           pix_mode,
    input  logic                 disp_en,
    input  logic                 vid_out,
    input  logic                 interlace,
    input  logic                 blank_req,
    input  logic [COLOR_W-1:0]   border_rgb,
    output logic [ADDR_W-1:0]    fb_base,
    output logic [FIELD_W+2:0]   fb_row_bytes,
    output logic [FIELD_W+1:0]   fb_hres,
    output logic [FIELD_W+1:0]   fb_vres,
    output logic [1:0]           fb_fmt,
    output logic                 fb_enable,
    output logic                 fb_blank,
    output logic [COLOR_W-1:0]   fb_fill,
    output logic                 fmt_changed
);
    localparam int HRES_W = FIELD_W + 2;
    localparam int VRES_W = FIELD_W + 2;
    localparam int ROWB_W = FIELD_W + 3;

    logic [FIELD_W:0]  words;
    logic [FIELD_W:0]  lines;
    logic [ROWB_W-1:0] row_bytes;
    logic [HRES_W-1:0] hres_new;
    logic [VRES_W-1:0] vres_new;
    pix_fmt_t          fmt_new;
    logic              out_on;
    logic              on_tick;
    logic              off_tick;
    logic              differs;

    disp_state_t state, state_nxt;

    assign fmt_new  = pix_fmt_t'(pix_mode);
    assign out_on   = disp_en & vid_out;
    assign on_tick  = frame_tick & out_on;
    assign off_tick = frame_tick & ~out_on;
    assign vres_new = interlace ? {lines, 1'b0} : {1'b0, lines};

    fpd_geom_unpack #(.FIELD_W(FIELD_W)) u_unpack (
        .geom      (geom_reg),
        .words     (words),
        .lines     (lines),
        .row_bytes (row_bytes)
    );

    fpd_hres_calc #(.FIELD_W(FIELD_W)) u_hres (
        .words (words),
        .fmt   (fmt_new),
        .hres  (hres_new)
    );

    fpd_slot_pair #(.HRES_W(HRES_W), .VRES_W(VRES_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (on_tick),
        .clr     (off_tick),
        .hres_in (hres_new),
        .vres_in (vres_new),
        .fmt_in  (fmt_new),
        .differs (differs)
    );

    // transitions: go_off, go_blank, go_show (only on frame_tick)
    always_comb begin
        state_nxt = state;
        if (frame_tick) begin
            unique case (state)
                ST_OFF, ST_SHOW, ST_BLANK: begin
                    if (!out_on)        state_nxt = ST_OFF;
                    else if (blank_req) state_nxt = ST_BLANK;
                    else                state_nxt = ST_SHOW;
                end
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_base      <= '0;
            fb_row_bytes <= '0;
            fb_hres      <= '0;
            fb_vres      <= '0;
            fb_fmt       <= '0;
            fb_fill      <= '0;
            fmt_changed  <= 1'b0;
        end else begin
            fmt_changed <= 1'b0;
            if (on_tick) begin
                fb_base      <= disp_base;
                fb_row_bytes <= row_bytes;
                fb_hres      <= hres_new;
                fb_vres      <= vres_new;
                fb_fmt       <= fmt_new;
                fb_fill      <= border_rgb;
                fmt_changed  <= differs;
            end
        end
    end

    assign fb_enable = (state != ST_OFF);
    assign fb_blank  = (state == ST_BLANK);

endmodule

// File: rtl/frame_param_decoder_chk.sv
module frame_param_decoder_chk #(
    parameter int ADDR_W  = 24,
    parameter int FIELD_W = 10,
    parameter int COLOR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_tick,
    input logic [1:0]         pix_mode,
    input logic               disp_en,
    input logic               vid_out,
    input logic               blank_req,
    input logic [COLOR_W-1:0] border_rgb,
    input logic [ADDR_W-1:0]  fb_base,
    input logic [FIELD_W+1:0] fb_hres,
    input logic [FIELD_W+1:0] fb_vres,
    input logic [1:0]         fb_fmt,
    input logic               fb_enable,
    input logic               fb_blank,
    input logic [COLOR_W-1:0] fb_fill,
    input logic               fmt_changed
);
    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && !(disp_en && vid_out) |=> !fb_enable && !fb_blank);

    // R6
    blank_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && disp_en && vid_out && blank_req |=> fb_blank && fb_fill == $past(border_rgb));

    // R4
    fmt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && disp_en && vid_out |=> fb_fmt == $past(pix_mode));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(fb_hres) && $stable(fb_vres) && $stable(fb_base) && $stable(fb_enable));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> !fmt_changed);

    // R9
    off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick && !(disp_en && vid_out) |=> !fmt_changed);

endmodule

bind frame_param_decoder frame_param_decoder_chk #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .COLOR_W(COLOR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pix_mode(pix_mode),
    .disp_en(disp_en), .vid_out(vid_out), .blank_req(blank_req),
    .border_rgb(border_rgb), .fb_base(fb_base), .fb_hres(fb_hres),
    .fb_vres(fb_vres), .fb_fmt(fb_fmt), .fb_enable(fb_enable),
    .fb_blank(fb_blank), .fb_fill(fb_fill), .fmt_changed(fmt_changed)
);

// File: tb/test_frame_param_decoder.sv
module test_frame_param_decoder;
    localparam int ADDR_W  = 24;
    localparam int FIELD_W = 10;
    localparam int COLOR_W = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_tick = 1'b0;
    logic [ADDR_W-1:0]    disp_base = '0;
    logic [3*FIELD_W-1:0] geom_reg = '0;
    logic [1:0]           pix_mode = '0;
    logic                 disp_en = 1'b0;
    logic                 vid_out = 1'b0;
    logic                 interlace = 1'b0;
    logic                 blank_req = 1'b0;
    logic [COLOR_W-1:0]   border_rgb = '0;
    logic [ADDR_W-1:0]    fb_base;
    logic [FIELD_W+2:0]   fb_row_bytes;
    logic [FIELD_W+1:0]   fb_hres;
    logic [FIELD_W+1:0]   fb_vres;
    logic [1:0]           fb_fmt;
    logic                 fb_enable;
    logic                 fb_blank;
    logic [COLOR_W-1:0]   fb_fill;
    logic                 fmt_changed;

    int n_vec = 0;
    int n_bad = 0;

    // bench model state
    int  m_ptr = 0;
    int  m_h[2] = '{0, 0};
    int  m_v[2] = '{0, 0};
    int  m_f[2] = '{0, 0};
    longint e_base = 0, e_rb = 0, e_h = 0, e_v = 0, e_f = 0, e_fill = 0;
    int  e_en = 0, e_bl = 0, e_chg = 0;

    always #10 clk = ~clk;

    frame_param_decoder #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .COLOR_W(COLOR_W)) i_frame_param_decoder (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .disp_base(disp_base),
        .geom_reg(geom_reg), .pix_mode(pix_mode), .disp_en(disp_en), .vid_out(vid_out),
        .interlace(interlace), .blank_req(blank_req), .border_rgb(border_rgb),
        .fb_base(fb_base), .fb_row_bytes(fb_row_bytes), .fb_hres(fb_hres),
        .fb_vres(fb_vres), .fb_fmt(fb_fmt), .fb_enable(fb_enable), .fb_blank(fb_blank),
        .fb_fill(fb_fill), .fmt_changed(fmt_changed)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string when);
        chk(fb_base == e_base,      "R6 base",      fb_base, e_base);
        chk(fb_row_bytes == e_rb,   "R2 row_bytes", fb_row_bytes, e_rb);
        chk(fb_vres == e_v,         "R3 vres",      fb_vres, e_v);
        chk(fb_hres == e_h,         "R4 hres",      fb_hres, e_h);
        chk(fb_fmt == e_f,          "R4 fmt",       fb_fmt, e_f);
        chk(fb_enable == e_en,      "R5 enable",    fb_enable, e_en);
        chk(fb_blank == e_bl,       "R6 blank",     fb_blank, e_bl);
        chk(fb_fill == e_fill,      "R6 fill",      fb_fill, e_fill);
        chk(fmt_changed == e_chg,   "R8 pulse",     fmt_changed, e_chg);
        if (when.len() == 0) n_vec += 0;
    endtask

    task automatic set_regs(input int mode, input int w, input int l, input int s,
                            input bit il, input bit de, input bit vo, input bit bk,
                            input int border, input int base);
        geom_reg   = {s[FIELD_W-1:0], l[FIELD_W-1:0], w[FIELD_W-1:0]};
        pix_mode   = mode[1:0];
        interlace  = il;
        disp_en    = de;
        vid_out    = vo;
        blank_req  = bk;
        border_rgb = border;
        disp_base  = base[ADDR_W-1:0];
    endtask

    // one strobe, model update, check after capture, then check pulse drop
    task automatic frame();
        int w, l, s, h, v, f, other;
        w = int'(geom_reg[FIELD_W-1:0]);
        l = int'(geom_reg[FIELD_W +: FIELD_W]);
        s = int'(geom_reg[2*FIELD_W +: FIELD_W]);
        f = int'(pix_mode);
        @(negedge clk) frame_tick = 1'b1;
        if (disp_en && vid_out) begin
            case (f)
                0, 1: h = 2 * (w + 1);
                2:    h = (4 * (w + 1)) / 3;
                default: h = w + 1;
            endcase
            v = interlace ? 2 * (l + 1) : (l + 1);
            other = 1 - m_ptr;
            e_chg = (h != m_h[other]) || (v != m_v[other]) || (f != m_f[other]);
            m_h[m_ptr] = h; m_v[m_ptr] = v; m_f[m_ptr] = f;
            m_ptr = other;
            e_base = disp_base; e_rb = 4 * (w + s); e_h = h; e_v = v; e_f = f;
            e_fill = border_rgb; e_en = 1; e_bl = blank_req;
        end else begin
            m_ptr = 0; m_h[0] = 0; m_v[0] = 0;
            e_en = 0; e_bl = 0; e_chg = 0;
        end
        @(negedge clk) frame_tick = 1'b0;
        check_all("tick");
        e_chg = 0;
        @(negedge clk);
        check_all("after");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("reset");

        // R2 R3 R4: sweep every mode, mode 2 over the full words field
        for (int mode = 0; mode < 4; mode++) begin
            for (int w = 0; w < 1024; w += ((mode == 2) ? 1 : 29)) begin
                set_regs(mode, w, (w * 7 + 3) % 1024, (w * 13 + 1) % 1024,
                         w[0], 1'b1, 1'b1, w[1] & w[2], w * 11 + 5, w * 97);
                frame();
            end
            set_regs(mode, 1023, 1023, 1023, 1'b1, 1'b1, 1'b1, 1'b0, 7, 99);
            frame();
        end

        // R5: each enable combination
        for (int k = 0; k < 4; k++) begin
            set_regs(3, 100 + k, 50, 2, 1'b0, k[0], k[1], 1'b1, 33, 4096);
            frame();
        end

        // R7: inputs move without a strobe, outputs must hold
        set_regs(1, 40, 60, 3, 1'b0, 1'b1, 1'b1, 1'b0, 21, 512);
        frame();
        set_regs(2, 700, 200, 9, 1'b1, 1'b0, 1'b1, 1'b1, 77, 1234);
        repeat (4) @(negedge clk);
        check_all("R7 hold");

        // R9 with R8: A, B, A, off, B -> last B must not pulse
        set_regs(0, 10, 20, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1, 100);  frame();
        set_regs(3, 30, 40, 1, 1'b1, 1'b1, 1'b1, 1'b1, 2, 200);  frame();
        set_regs(0, 10, 20, 1, 1'b0, 1'b1, 1'b1, 1'b0, 3, 300);  frame();
        chk(e_chg == 0 && fmt_changed == 0, "R8 pulse dropped", fmt_changed, 0);
        set_regs(0, 10, 20, 1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 400);  frame();
        set_regs(3, 30, 40, 1, 1'b1, 1'b1, 1'b1, 1'b0, 5, 500);
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        // R9 pointer reset: new B lands in slot 0 and matches B in slot 1
        chk(fmt_changed == 1'b0, "R9 no pulse after off", fmt_changed, 0);
        chk(fb_enable == 1'b1, "R5 re-enable", fb_enable, 1);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule